// File: doc/BRIEF.md
# Standby Power-Down Sequencer

This block moves a processor subsystem between three power states: running, ordinary sleep and clock-stopped standby. The CPU programs a standby-enable bit and a watchdog control word and counter through a small register-write port, then raises a sleep strobe. The value of the standby-enable bit at that moment chooses between ordinary sleep and standby. In both low-power states the internal clock enable is dropped, and a two-pin status code tells the outside world which state is active.

Entering standby raises a one-cycle clear strobe for the timer unit's start register and a one-cycle initialise strobe for the A/D converter. All other peripheral registers keep their contents, so they get no strobe. A wakeup request in ordinary sleep restores clocks on the next cycle. In standby the watchdog counter becomes an oscillation-settling timer. It counts up from the value software left in it, at a rate set by a 3-bit prescale select, and clocks stay gated until it overflows. In running and sleep states the same counter acts as an ordinary watchdog when enabled, and it signals its wrap with a one-cycle pulse.

Top module: `stby_pwr_ctrl`

## Requirements
- R1: After power-on reset `clk_en` is 1, `status_pins` is 00, both init strobes and `wdt_ovf` are 0, the standby-enable bit is 0 and the watchdog is disabled.
- R2: A sleep strobe in the running state while the standby-enable bit is 0 enters ordinary sleep. From the next cycle `status_pins` is 10 (bit 1 is STATUS1) and `clk_en` is 0. A wakeup request in sleep returns to running on the following cycle.
- R3: A sleep strobe in the running state while the standby-enable bit is 1 enters standby. From the next cycle `status_pins` is 01 (STATUS1 = 0, STATUS0 = 1) and `clk_en` is 0.
- R4: In the first standby cycle, and only then, `tmr_start_clr` and `adc_init` are both 1. Ordinary sleep raises neither.
- R5: Register writes use `reg_sel`: 0 selects the standby-enable bit (data bit 0), 1 selects watchdog control (bit 7 enable, bits 2:0 prescale select), and 2 selects the counter. A write in the same cycle as the sleep strobe does not affect the decision, which uses the bit value held before that write.
- R6: A wakeup request in standby starts the settling count. The counter advances from its stored value c0 once per prescale period, and `clk_en` returns exactly (256 - c0) x div cycles after the edge that sampled the wakeup. `status_pins` stays 01 until then.
- R7: Prescale select values 0 to 7 give div = 1, 4, 16, 32, 64, 256, 1024 and 4096 clocks per counter step.
- R8: On the edge where the settling count overflows, the block returns to running, so `clk_en` = 1 and `status_pins` = 00 in the very next cycle.
- R9: Register writes are ignored during standby and settling, so a counter write made there does not change the settling time.
- R10: With the watchdog enabled in the running or sleep state, a counter wrap from 255 to 0 gives a one-cycle `wdt_ovf` pulse (256 - c0) x div cycles after enabling. A disabled watchdog and the settling overflow never raise it.
- R11: A sleep strobe outside the running state and a wakeup request in the running state have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 standby bit, 1 watchdog control, 2 counter |
| reg_wdata | input | 8 | Register write data |
| sleep_strobe | input | 1 | Sleep instruction executed |
| wake_req | input | 1 | Interrupt or other wakeup request |
| clk_en | output | 1 | Internal clock enable, 0 in sleep, standby and settling |
| status_pins | output | 2 | Power state code {STATUS1, STATUS0}: 00 run, 10 sleep, 01 standby |
| tmr_start_clr | output | 1 | One-cycle clear of the timer unit start register |
| adc_init | output | 1 | One-cycle initialise of all A/D converter registers |
| wdt_ovf | output | 1 | One-cycle watchdog wrap pulse in running or sleep state |

## Verification
A register write to the standby-enable bit and the sleep strobe can fall in the same cycle. The write updates the bit at that edge while the entry decision reads the old value. The bench provokes this in both directions: it writes 1 while the bit is 0 and expects ordinary sleep, then writes 0 while the bit is 1 and expects standby with its init strobes. A later plain sleep then shows that each write did land.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_STBY   = 2'd2,
    ST_SETTLE = 2'd3
  } pstate_t;

  localparam logic [1:0] SEL_STBY = 2'd0;
  localparam logic [1:0] SEL_WCTL = 2'd1;
  localparam logic [1:0] SEL_WCNT = 2'd2;

  // Prescale select to (divider - 1), the terminal count of the prescaler.
  function automatic logic [11:0] cks_term(input logic [2:0] cks);
    case (cks)
      3'd0:    return 12'd0;
      3'd1:    return 12'd3;
      3'd2:    return 12'd15;
      3'd3:    return 12'd31;
      3'd4:    return 12'd63;
      3'd5:    return 12'd255;
      3'd6:    return 12'd1023;
      default: return 12'd4095;
    endcase
  endfunction

  // Two-pin power code {STATUS1, STATUS0}.
  function automatic logic [1:0] state_code(input pstate_t s);
    case (s)
      ST_RUN:   return 2'b00;
      ST_SLEEP: return 2'b10;
      default:  return 2'b01;
    endcase
  endfunction

endpackage

// File: rtl/spd_regs.sv
module spd_regs #(
  parameter int DW    = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [DW-1:0]    wdata,
  input  logic             wr_allow,
  output logic             stby_bit,
  output logic             wdt_en,
  output logic [2:0]       cks,
  output logic             cnt_ld,
  output logic [CNT_W-1:0] cnt_ld_val
);
  import spd_pkg::*;

  localparam int EN_POS = DW - 1;

  logic wr_ok;
  assign wr_ok      = wr_en && wr_allow;
  assign cnt_ld     = wr_ok && (sel == SEL_WCNT);
  assign cnt_ld_val = wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_bit <= 1'b0;
      wdt_en   <= 1'b0;
      cks      <= 3'd0;
    end else if (wr_ok) begin
      if (sel == SEL_STBY) stby_bit <= wdata[0];
      if (sel == SEL_WCTL) begin
        wdt_en <= wdata[EN_POS];
        cks    <= wdata[2:0];
      end
    end
  end

endmodule

// File: rtl/spd_wdt.sv
module spd_wdt #(
  parameter int CNT_W = 8,
  parameter int PS_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cks,
  input  logic             count_en,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic             wrap
);
  import spd_pkg::*;

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [PS_W-1:0]  ps_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PS_W-1:0]  term;
  logic             tick;

  assign term = PS_W'(cks_term(cks));
  assign tick = count_en && (ps_q >= term);
  assign wrap = tick && !ld && (cnt_q == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (!count_en || tick) ps_q <= '0;
      else                   ps_q <= ps_q + 1'b1;
      if (ld)        cnt_q <= ld_val;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spd_fsm.sv
module spd_fsm (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_strobe,
  input  logic             wake_req,
  input  logic             stby_bit,
  input  logic             wrap,
  output spd_pkg::pstate_t state,
  output logic             settle_done,
  output logic             init_pulse,
  output logic             ovf_pulse
);
  import spd_pkg::*;

  pstate_t nxt;
  logic    go_stby;

  assign go_stby     = (state == ST_RUN) && sleep_strobe && stby_bit;
  assign settle_done = (state == ST_SETTLE) && wrap;

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN:    if (sleep_strobe) nxt = stby_bit ? ST_STBY : ST_SLEEP;
      ST_SLEEP:  if (wake_req)     nxt = ST_RUN;
      ST_STBY:   if (wake_req)     nxt = ST_SETTLE;
      ST_SETTLE: if (wrap)         nxt = ST_RUN;
      default:                     nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      init_pulse <= 1'b0;
      ovf_pulse  <= 1'b0;
    end else begin
      state      <= nxt;
      init_pulse <= go_stby;
      ovf_pulse  <= wrap && ((state == ST_RUN) || (state == ST_SLEEP));
    end
  end

endmodule

// File: rtl/stby_pwr_ctrl.sv
module stby_pwr_ctrl #(
  parameter int DW    = 8,
  parameter int CNT_W = 8,
  parameter int PS_W  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic          sleep_strobe,
  input  logic          wake_req,
  output logic          clk_en,
  output logic [1:0]    status_pins,
  output logic          tmr_start_clr,
  output logic          adc_init,
  output logic          wdt_ovf
);
  import spd_pkg::*;

  pstate_t          state;
  logic [1:0]       state_bits;
  logic             awake;
  logic             stby_bit;
  logic             wdt_en;
  logic [2:0]       cks;
  logic             cnt_ld;
  logic [CNT_W-1:0] cnt_ld_val;
  logic             count_en;
  logic             wrap;
  logic             settle_done;
  logic             init_pulse;

  assign state_bits = state;
  assign awake      = (state == ST_RUN) || (state == ST_SLEEP);
  assign count_en   = (wdt_en && awake) || (state == ST_SETTLE);

  spd_regs #(.DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(reg_sel),
    .wdata(reg_wdata), .wr_allow(awake), .stby_bit(stby_bit),
    .wdt_en(wdt_en), .cks(cks), .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val)
  );

  spd_wdt #(.CNT_W(CNT_W), .PS_W(PS_W)) u_wdt (
    .clk(clk), .rst_n(rst_n), .cks(cks), .count_en(count_en),
    .ld(cnt_ld), .ld_val(cnt_ld_val), .wrap(wrap)
  );

  spd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sleep_strobe(sleep_strobe),
    .wake_req(wake_req), .stby_bit(stby_bit), .wrap(wrap),
    .state(state), .settle_done(settle_done),
    .init_pulse(init_pulse), .ovf_pulse(wdt_ovf)
  );

  assign clk_en        = (state == ST_RUN);
  assign status_pins   = state_code(state);
  assign tmr_start_clr = init_pulse;
  assign adc_init      = init_pulse;

endmodule

// File: rtl/spd_chk.sv
module spd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state_bits,
  input logic       sleep_strobe,
  input logic       wake_req,
  input logic       stby_bit,
  input logic       reg_wr_en,
  input logic       settle_done,
  input logic       clk_en,
  input logic [1:0] status_pins,
  input logic       tmr_start_clr,
  input logic       adc_init,
  input logic       wdt_ovf
);

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_bits == 2'd0 && sleep_strobe && !stby_bit) |=> (status_pins == 2'b10 && !clk_en)); // R2

  AST_STBY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_bits == 2'd0 && sleep_strobe && stby_bit) |=> (status_pins == 2'b01 && !clk_en && tmr_start_clr && adc_init)); // R3

  AST_INIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_start_clr |=> !tmr_start_clr); // R4

  AST_INIT_IN_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    adc_init |-> (status_pins == 2'b01)); // R4

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    settle_done |=> (clk_en && status_pins == 2'b00)); // R8

  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_bits[1] && reg_wr_en) |=> $stable(stby_bit)); // R9

  AST_OVF_NOT_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_ovf |-> ($past(state_bits) != 2'd3)); // R10

  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_ovf |=> !wdt_ovf); // R10

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_bits == 2'd1 && !wake_req) |=> (status_pins == 2'b10)); // R11

  AST_WAKE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_bits == 2'd0 && wake_req && !sleep_strobe) |=> clk_en); // R11

endmodule

bind stby_pwr_ctrl spd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state_bits(state_bits),
  .sleep_strobe(sleep_strobe), .wake_req(wake_req), .stby_bit(stby_bit),
  .reg_wr_en(reg_wr_en), .settle_done(settle_done), .clk_en(clk_en),
  .status_pins(status_pins), .tmr_start_clr(tmr_start_clr),
  .adc_init(adc_init), .wdt_ovf(wdt_ovf)
);

// File: tb/sim_stby_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_stby_pwr_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       sleep_strobe = 1'b0;
  logic       wake_req = 1'b0;
  logic       clk_en;
  logic [1:0] status_pins;
  logic       tmr_start_clr;
  logic       adc_init;
  logic       wdt_ovf;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  stby_pwr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .sleep_strobe(sleep_strobe), .wake_req(wake_req),
    .clk_en(clk_en), .status_pins(status_pins), .tmr_start_clr(tmr_start_clr),
    .adc_init(adc_init), .wdt_ovf(wdt_ovf)
  );

  // Vector fields: {standby bit, prescale select[2:0], counter start[7:0]}
  localparam logic [11:0] VEC [10] = '{
    {1'b0, 3'd0, 8'h00},
    {1'b1, 3'd0, 8'h00},
    {1'b1, 3'd1, 8'hC0},
    {1'b1, 3'd2, 8'hF0},
    {1'b1, 3'd3, 8'hF8},
    {1'b1, 3'd4, 8'hFC},
    {1'b1, 3'd5, 8'hFF},
    {1'b1, 3'd6, 8'hFF},
    {1'b1, 3'd7, 8'hFF},
    {1'b0, 3'd5, 8'h10}
  };

  function automatic int exp_div(input int c);
    if (c == 0) return 1;
    if (c < 3)  return 1 << (2 * c);
    if (c < 5)  return 32 << (c - 3);
    return 256 << (2 * (c - 5));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic pulse_sleep();
    @(negedge clk); sleep_strobe = 1'b1;
    @(negedge clk); sleep_strobe = 1'b0;
  endtask

  // Pulse wake, then count cycles until clocks return; checks status and ovf on the way.
  task automatic wake_and_measure(output int gap, output bit status_ok, output bit ovf_seen);
    int n;
    @(negedge clk); wake_req = 1'b1;
    @(negedge clk); wake_req = 1'b0;
    n = 1; status_ok = 1'b1; ovf_seen = 1'b0;
    while (!clk_en && n < 20000) begin
      if (status_pins != 2'b01) status_ok = 1'b0;
      if (wdt_ovf) ovf_seen = 1'b1;
      @(negedge clk); n++;
    end
    if (wdt_ovf) ovf_seen = 1'b1;
    gap = n - 1;
  endtask

  task automatic cycles_to_ovf(output int gap);
    int n;
    n = 1;
    while (!wdt_ovf && n < 20000) begin
      @(negedge clk); n++;
    end
    gap = n - 1;
  endtask

  initial begin
    int gap;
    bit sok, ovf;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 clk_en", clk_en, 1);
    check("R1 status", status_pins, 0);
    check("R1 strobes", {tmr_start_clr, adc_init, wdt_ovf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 standby bit cleared: plain sleep gives ordinary sleep
    pulse_sleep();
    check("R1 stby bit reset", status_pins, 2'b10);
    wake_and_measure(gap, sok, ovf);

    // Vector walk: R2 R3 R4 R6 R7 R8 R9
    for (int i = 0; i < 10; i++) begin
      logic       sb;
      logic [2:0] ck;
      logic [7:0] c0;
      int         expect_gap;
      sb = VEC[i][11]; ck = VEC[i][10:8]; c0 = VEC[i][7:0];
      wr(2'd0, {7'd0, sb});
      wr(2'd1, {5'd0, ck});
      wr(2'd2, c0);
      pulse_sleep();
      check(sb ? "R3 status" : "R2 status", status_pins, sb ? 2'b01 : 2'b10);
      check("R2 R3 clk_en low", clk_en, 0);
      check("R4 init strobes", {tmr_start_clr, adc_init}, sb ? 2'b11 : 2'b00);
      @(negedge clk);
      check("R4 single cycle", {tmr_start_clr, adc_init}, 0);
      if (sb) wr(2'd2, 8'h80); // R9 ignored in standby
      expect_gap = sb ? (256 - int'(c0)) * exp_div(int'(ck)) : 0;
      wake_and_measure(gap, sok, ovf);
      check(sb ? "R6 R7 R9 settle cycles" : "R2 wake", gap, expect_gap);
      check("R8 release status", status_pins, 0);
      check("R6 status held", sok, 1);
      check("R10 no ovf while settling", ovf, 0);
    end

    // R5 same-cycle write and sleep: bit 0 -> write 1
    wr(2'd0, 8'd0);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 2'd0; reg_wdata = 8'd1; sleep_strobe = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; sleep_strobe = 1'b0;
    check("R5 old bit 0 gives sleep", status_pins, 2'b10);
    check("R5 no strobe", tmr_start_clr, 0);
    wake_and_measure(gap, sok, ovf);
    // R5 bit 1 -> write 0
    wr(2'd1, 8'd0);
    wr(2'd2, 8'hFF);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 2'd0; reg_wdata = 8'd0; sleep_strobe = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; sleep_strobe = 1'b0;
    check("R5 old bit 1 gives standby", status_pins, 2'b01);
    check("R5 standby strobe", adc_init, 1);
    wake_and_measure(gap, sok, ovf);
    check("R5 settle one step", gap, 1);
    pulse_sleep();
    check("R5 write landed", status_pins, 2'b10);

    // R11 sleep strobe while asleep ignored
    pulse_sleep();
    check("R11 sleep in sleep", status_pins, 2'b10);
    check("R11 no strobe", tmr_start_clr, 0);
    wake_and_measure(gap, sok, ovf);
    check("R11 wake from sleep", clk_en, 1);
    // R11 wake in run ignored
    @(negedge clk); wake_req = 1'b1;
    @(negedge clk); wake_req = 1'b0;
    check("R11 wake in run", {clk_en, status_pins}, 3'b100);

    // R10 watchdog in running state
    wr(2'd2, 8'hFE);
    wr(2'd1, 8'h80);
    cycles_to_ovf(gap);
    check("R10 ovf timing div1", gap, 2);
    @(negedge clk);
    check("R10 ovf one cycle", wdt_ovf, 0);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hFC);
    wr(2'd1, 8'h81);
    cycles_to_ovf(gap);
    check("R10 R7 ovf timing div4", gap, 16);
    wr(2'd1, 8'h00);
    begin
      bit seen;
      seen = 1'b0;
      repeat (600) begin @(negedge clk); if (wdt_ovf) seen = 1'b1; end
      check("R10 disabled no ovf", seen, 0);
    end

    // R1 reset during standby
    wr(2'd0, 8'd1);
    wr(2'd2, 8'hF0);
    wr(2'd1, 8'h80);
    pulse_sleep();
    check("R3 standby before reset", status_pins, 2'b01);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset in standby", {clk_en, status_pins}, 3'b100);
    rst_n = 1'b1;
    begin
      bit seen;
      seen = 1'b0;
      repeat (300) begin @(negedge clk); if (wdt_ovf) seen = 1'b1; end
      check("R1 watchdog stopped", seen, 0);
    end
    pulse_sleep();
    check("R1 stby bit cleared", status_pins, 2'b10);
    wake_and_measure(gap, sok, ovf);

    finish_run();
  end

endmodule